// File: doc/BRIEF.md
# External Data Address Generator

This block forms the 16-bit external data memory address for a small 8-bit microcontroller core. It holds two 16-bit data pointers, a one-bit pointer-select register and an 8-bit page register. The core's instruction decoder sends it one decoded operation per cycle: a paged read or write, a pointer-based read or write, a pointer load, or a pointer increment. A narrow special-function-register port lets software read and write the registers directly.

A paged access combines the page register, as the high byte, with an 8-bit register value that the decoder supplies, as the low byte. A pointer-based access places the whole selected pointer on the bus. Both kinds can be mixed freely. For each access the block registers the address, a read or write strobe and the write data. One cycle later it returns the read data with a valid flag. The decoder, the ALU and the memory itself are outside the block.

Top module: `xdata_addr_gen`

## Requirements
- R1: After reset, both pointers, the select register and the page register read as zero, and `mem_rd`, `mem_wr` and `rd_valid` are low.
- R2: A paged access drives `mem_addr` with the page register in bits 15:8 and `op_reg_lo` in bits 7:0.
- R3: A pointer-based access drives `mem_addr` with the full 16-bit value of the selected pointer. The `op_code` encodings are: 0 none, 1 paged read, 2 paged write, 3 pointer read, 4 pointer write, 5 pointer load from `op_imm`, 6 pointer increment.
- R4: Select bit 0 chooses the pointer (0 primary, 1 secondary). Writes to select bits 7:1 are ignored, and those bits read back as zero. The SFR addresses are: 0 pointer low byte, 1 pointer high byte, 2 select, 3 page.
- R5: Writing the select register leaves the stored values of both pointers unchanged.
- R6: Pointer load, increment, external access and SFR byte reads and writes act only on the selected pointer. The other pointer keeps its value.
- R7: Increment adds one to the selected pointer and wraps from 0xFFFF to 0x0000.
- R8: In the cycle after a request, the address and strobe (`mem_rd` or `mem_wr`, never both) are valid, with `mem_wdata` carrying `op_wdata` on writes. The strobe falls after one cycle unless another access follows.
- R9: One cycle after a read strobe, `rd_valid` is high and `rd_data` carries the `mem_rdata` sampled during the strobe.
- R10: Paged and pointer-based accesses interleave without interaction. Pointer operations never change the page register, and page writes never change a pointer.
- R11: When a pointer load or increment arrives in the same cycle as an SFR byte write to the selected pointer, the load or increment takes effect and the byte write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | SFR write enable |
| sfr_addr | input | 2 | SFR register select |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| op_code | input | 3 | Decoded operation request |
| op_reg_lo | input | 8 | Low address byte for paged access |
| op_imm | input | 16 | Immediate for pointer load |
| op_wdata | input | 8 | Data for external write |
| mem_addr | output | 16 | External data address |
| mem_rd | output | 1 | External read strobe |
| mem_wr | output | 1 | External write strobe |
| mem_wdata | output | 8 | External write data |
| mem_rdata | input | 8 | External read data |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | Read data valid |

## Verification
Paged accesses are tried with page and low-byte pairs at all zeros, all ones, a single high bit with a single low bit, and a mixed value. This shows whether the bytes are swapped, truncated or taken from the wrong source. Pointer accesses run with distinct values in the two pointers, so that a wrong select, a write to the unselected pointer or a value lost on a select change each produce a different mismatch. Paged and pointer operations are interleaved around a fixed page, and a load is made to collide with an SFR byte write. These show whether the two address sources stay independent and whether the write priority is right. An increment from 0xFFFF covers the wrap.

// File: rtl/xag_pkg.sv
package xag_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PAGED_RD = 3'd1,
    OP_PAGED_WR = 3'd2,
    OP_PTR_RD   = 3'd3,
    OP_PTR_WR   = 3'd4,
    OP_PTR_LOAD = 3'd5,
    OP_PTR_INC  = 3'd6
  } xag_op_e;

  typedef enum logic [1:0] {
    SFR_PTR_LO = 2'd0,
    SFR_PTR_HI = 2'd1,
    SFR_SELECT = 2'd2,
    SFR_PAGE   = 2'd3
  } xag_sfr_e;

  // page byte on top, register byte below
  function automatic logic [ADDR_W-1:0] paged_addr(input logic [DATA_W-1:0] page,
                                                   input logic [DATA_W-1:0] low);
    return {page, low};
  endfunction

  // modular step of a pointer
  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/xag_ctrl_regs.sv
module xag_ctrl_regs
  import xag_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [1:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] page_q
);
  logic sel_wr, page_wr;
  assign sel_wr  = sfr_we && (sfr_addr == SFR_SELECT);
  assign page_wr = sfr_we && (sfr_addr == SFR_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      page_q <= '0;
    end else begin
      if (sel_wr)  sel_q  <= sfr_wdata[SEL_W-1:0];
      if (page_wr) page_q <= sfr_wdata;
    end
  end
endmodule

// File: rtl/xag_ptr_bank.sv
module xag_ptr_bank
  import xag_pkg::*;
#(
  parameter int NUM_PTR = 2,
  parameter int SEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      load_en,
  input  logic [ADDR_W-1:0]         load_val,
  input  logic                      inc_en,
  input  logic                      byte_we,
  input  logic                      byte_hi,
  input  logic [DATA_W-1:0]         byte_val,
  output logic [NUM_PTR*ADDR_W-1:0] ptr_flat,
  output logic [ADDR_W-1:0]         ptr_cur
);
  logic [ADDR_W-1:0] ptr_q [NUM_PTR];

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic hit;
    assign hit = (sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[i] <= '0;
      end else if (hit) begin
        if (load_en)      ptr_q[i] <= load_val;
        else if (inc_en)  ptr_q[i] <= ptr_step(ptr_q[i]);
        else if (byte_we) begin
          if (byte_hi) ptr_q[i][ADDR_W-1:DATA_W] <= byte_val;
          else         ptr_q[i][DATA_W-1:0]      <= byte_val;
        end
      end
    end

    assign ptr_flat[i*ADDR_W +: ADDR_W] = ptr_q[i];
  end

  assign ptr_cur = ptr_q[sel];
endmodule

// File: rtl/xag_bus_port.sv
module xag_bus_port
  import xag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] addr_next,
  input  logic [DATA_W-1:0] wdata_next,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      mem_rd   <= acc_rd;
      mem_wr   <= acc_wr;
      rd_valid <= mem_rd;
      if (acc_rd || acc_wr) mem_addr  <= addr_next;
      if (acc_wr)           mem_wdata <= wdata_next;
      if (mem_rd)           rd_data   <= mem_rdata;
    end
  end
endmodule

// File: rtl/xdata_addr_gen.sv
module xdata_addr_gen
  import xag_pkg::*;
#(
  parameter int NUM_PTR = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_we,
  input  logic [1:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic [2:0]  op_code,
  input  logic [7:0]  op_reg_lo,
  input  logic [15:0] op_imm,
  input  logic [7:0]  op_wdata,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  rd_data,
  output logic        rd_valid
);
  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  // named internal events
  logic [SEL_W-1:0]          sel_q;
  logic [DATA_W-1:0]         page_q;
  logic [NUM_PTR*ADDR_W-1:0] ptr_flat;
  logic [ADDR_W-1:0]         ptr_cur;
  logic [ADDR_W-1:0]         addr_next;
  logic acc_paged, acc_rd, acc_wr, load_en, inc_en, byte_we, byte_hi;

  assign acc_paged = (op_code == OP_PAGED_RD) || (op_code == OP_PAGED_WR);
  assign acc_rd    = (op_code == OP_PAGED_RD) || (op_code == OP_PTR_RD);
  assign acc_wr    = (op_code == OP_PAGED_WR) || (op_code == OP_PTR_WR);
  assign load_en   = (op_code == OP_PTR_LOAD);
  assign inc_en    = (op_code == OP_PTR_INC);
  assign byte_we   = sfr_we && ((sfr_addr == SFR_PTR_LO) || (sfr_addr == SFR_PTR_HI));
  assign byte_hi   = (sfr_addr == SFR_PTR_HI);
  assign addr_next = acc_paged ? paged_addr(page_q, op_reg_lo) : ptr_cur;

  xag_ctrl_regs #(.SEL_W(SEL_W)) u_ctrl (
    .clk, .rst_n, .sfr_we, .sfr_addr, .sfr_wdata,
    .sel_q, .page_q
  );

  xag_ptr_bank #(.NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_bank (
    .clk, .rst_n, .sel(sel_q), .load_en, .load_val(op_imm), .inc_en,
    .byte_we, .byte_hi, .byte_val(sfr_wdata), .ptr_flat, .ptr_cur
  );

  xag_bus_port u_bus (
    .clk, .rst_n, .acc_rd, .acc_wr, .addr_next, .wdata_next(op_wdata),
    .mem_rdata, .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .rd_data, .rd_valid
  );

  always_comb begin
    unique case (sfr_addr)
      SFR_PTR_LO: sfr_rdata = ptr_cur[DATA_W-1:0];
      SFR_PTR_HI: sfr_rdata = ptr_cur[ADDR_W-1:DATA_W];
      SFR_SELECT: sfr_rdata = DATA_W'(sel_q);
      default:    sfr_rdata = page_q;
    endcase
  end
endmodule

// File: rtl/xag_checker.sv
module xag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op_code,
  input logic [7:0]  op_reg_lo,
  input logic        sfr_we,
  input logic [1:0]  sfr_addr,
  input logic [15:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        rd_valid,
  input logic [7:0]  page_q,
  input logic        sel_q,
  input logic [15:0] ptr0,
  input logic [15:0] ptr1
);
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_rd_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1 || op_code == 3'd3) |=> mem_rd);

  assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> rd_valid);

  assert_paged_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1 || op_code == 3'd2) |=> mem_addr == {$past(page_q), $past(op_reg_lo)});

  assert_ptr_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3 || op_code == 3'd4) |=> mem_addr == $past(sel_q ? ptr1 : ptr0));

  assert_select_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == 2'd2 && op_code == 3'd0) |=> ($stable(ptr0) && $stable(ptr1)));

  assert_unsel_ptr1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> $stable(ptr1));

  assert_unsel_ptr0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> $stable(ptr0));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd6 && !sel_q && ptr0 == 16'hFFFF) |=> ptr0 == 16'h0000);

  assert_page_iso_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_we && sfr_addr == 2'd3) |=> $stable(page_q));
endmodule

bind xdata_addr_gen xag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_reg_lo(op_reg_lo),
  .sfr_we(sfr_we), .sfr_addr(sfr_addr), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_valid(rd_valid),
  .page_q(page_q), .sel_q(sel_q[0]),
  .ptr0(ptr_flat[15:0]), .ptr1(ptr_flat[31:16])
);

// File: tb/test_xdata_addr_gen.sv
module test_xdata_addr_gen;
  import xag_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [1:0]  sfr_addr = 2'd0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic [2:0]  op_code = 3'd0;
  logic [7:0]  op_reg_lo = 8'h00;
  logic [15:0] op_imm = 16'h0000;
  logic [7:0]  op_wdata = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata, rd_data;
  logic        rd_valid;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem [256];

  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  xdata_addr_gen i_xdata_addr_gen (
    .clk, .rst_n, .sfr_we, .sfr_addr, .sfr_wdata, .sfr_rdata,
    .op_code, .op_reg_lo, .op_imm, .op_wdata,
    .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .mem_rdata, .rd_data, .rd_valid
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sfr_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  // drive one op for one cycle; returns at the negedge where the bus is valid
  task automatic issue(input logic [2:0] op, input logic [7:0] lo,
                       input logic [15:0] imm, input logic [7:0] wd);
    @(negedge clk);
    op_code = op; op_reg_lo = lo; op_imm = imm; op_wdata = wd;
    @(negedge clk);
    op_code = OP_NONE;
  endtask

  task automatic read_ptr(output logic [15:0] v);
    logic [7:0] lo, hi;
    sfr_rd(SFR_PTR_LO, lo);
    sfr_rd(SFR_PTR_HI, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] p;
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 rd_valid", rd_valid, 0);
    read_ptr(p); chk("R1 ptr0", p, 16'h0000);
    sfr_rd(SFR_SELECT, d); chk("R1 select", d, 0);
    sfr_rd(SFR_PAGE, d); chk("R1 page", d, 0);
    sfr_wr(SFR_SELECT, 8'h01);
    read_ptr(p); chk("R1 ptr1", p, 16'h0000);
    sfr_wr(SFR_SELECT, 8'h00);
  endtask

  task automatic t_paged;
    logic [15:0] pats [4] = '{16'h0000, 16'h1234, 16'hFFFF, 16'h8001};
    for (int i = 0; i < 4; i++) begin
      logic [7:0] wd;
      wd = pats[i][7:0] ^ 8'hA5;
      sfr_wr(SFR_PAGE, pats[i][15:8]);
      issue(OP_PAGED_WR, pats[i][7:0], 16'h0, wd);
      chk("R2 paged wr addr", mem_addr, pats[i]);
      chk("R8 wr strobe", {mem_wr, mem_rd}, 2'b10);
      chk("R8 wdata", mem_wdata, wd);
      issue(OP_PAGED_RD, pats[i][7:0], 16'h0, 8'h00);
      chk("R2 paged rd addr", mem_addr, pats[i]);
      chk("R8 rd strobe", {mem_wr, mem_rd}, 2'b01);
      @(negedge clk);
      chk("R8 strobe drops", mem_rd, 0);
      chk("R9 rd_valid", rd_valid, 1);
      chk("R9 rd_data", rd_data, wd);
      @(negedge clk);
      chk("R9 valid drops", rd_valid, 0);
    end
  endtask

  task automatic t_pointer;
    issue(OP_PTR_LOAD, 8'h0, 16'h1234, 8'h0);
    chk("R8 load no strobe", {mem_wr, mem_rd}, 2'b00);
    issue(OP_PTR_WR, 8'h0, 16'h0, 8'h3C);
    chk("R3 ptr wr addr", mem_addr, 16'h1234);
    chk("R8 ptr wdata", mem_wdata, 8'h3C);
    issue(OP_PTR_RD, 8'h0, 16'h0, 8'h0);
    chk("R3 ptr rd addr", mem_addr, 16'h1234);
    @(negedge clk);
    chk("R9 ptr rd_data", rd_data, 8'h3C);
  endtask

  task automatic t_select;
    logic [15:0] p;
    logic [7:0] d;
    sfr_wr(SFR_SELECT, 8'h01);
    issue(OP_PTR_LOAD, 8'h0, 16'hBEEF, 8'h0);
    issue(OP_PTR_RD, 8'h0, 16'h0, 8'h0);
    chk("R4 secondary addr", mem_addr, 16'hBEEF);
    sfr_wr(SFR_SELECT, 8'h00);
    read_ptr(p); chk("R5 primary kept", p, 16'h1234);
    issue(OP_PTR_RD, 8'h0, 16'h0, 8'h0);
    chk("R4 primary addr", mem_addr, 16'h1234);
    sfr_wr(SFR_SELECT, 8'hFF);
    sfr_rd(SFR_SELECT, d); chk("R4 upper bits ignored", d, 8'h01);
    read_ptr(p); chk("R5 secondary kept", p, 16'hBEEF);
    sfr_wr(SFR_SELECT, 8'hFE);
    sfr_rd(SFR_SELECT, d); chk("R4 bit0 only", d, 8'h00);
    read_ptr(p); chk("R4 FE selects primary", p, 16'h1234);
  endtask

  task automatic t_isolation;
    logic [15:0] p;
    sfr_wr(SFR_PTR_LO, 8'hAA);
    sfr_wr(SFR_PTR_HI, 8'h55);
    read_ptr(p); chk("R6 byte writes", p, 16'h55AA);
    sfr_wr(SFR_SELECT, 8'h01);
    read_ptr(p); chk("R6 secondary untouched", p, 16'hBEEF);
    issue(OP_PTR_INC, 8'h0, 16'h0, 8'h0);
    read_ptr(p); chk("R6 inc secondary", p, 16'hBEF0);
    sfr_wr(SFR_SELECT, 8'h00);
    read_ptr(p); chk("R6 primary untouched", p, 16'h55AA);
  endtask

  task automatic t_wrap;
    logic [15:0] p;
    issue(OP_PTR_LOAD, 8'h0, 16'hFFFF, 8'h0);
    issue(OP_PTR_INC, 8'h0, 16'h0, 8'h0);
    read_ptr(p); chk("R7 wrap", p, 16'h0000);
    issue(OP_PTR_RD, 8'h0, 16'h0, 8'h0);
    chk("R7 wrap addr", mem_addr, 16'h0000);
    issue(OP_PTR_INC, 8'h0, 16'h0, 8'h0);
    read_ptr(p); chk("R7 plain inc", p, 16'h0001);
  endtask

  task automatic t_interleave;
    logic [15:0] p;
    logic [7:0] d;
    sfr_wr(SFR_PAGE, 8'h7C);
    issue(OP_PTR_LOAD, 8'h0, 16'h4000, 8'h0);
    issue(OP_PAGED_RD, 8'h11, 16'h0, 8'h0);
    chk("R10 paged after load", mem_addr, 16'h7C11);
    issue(OP_PTR_RD, 8'h0, 16'h0, 8'h0);
    chk("R10 ptr after paged", mem_addr, 16'h4000);
    issue(OP_PTR_INC, 8'h0, 16'h0, 8'h0);
    sfr_rd(SFR_PAGE, d); chk("R10 page kept", d, 8'h7C);
    issue(OP_PAGED_WR, 8'h22, 16'h0, 8'h99);
    chk("R10 paged after inc", mem_addr, 16'h7C22);
    sfr_wr(SFR_PAGE, 8'h01);
    read_ptr(p); chk("R10 ptr kept", p, 16'h4001);
    // back-to-back: paged then pointer in consecutive cycles
    @(negedge clk);
    op_code = OP_PAGED_RD; op_reg_lo = 8'h33;
    @(negedge clk);
    chk("R10 b2b paged", mem_addr, 16'h0133);
    op_code = OP_PTR_RD;
    @(negedge clk);
    op_code = OP_NONE;
    chk("R10 b2b ptr", mem_addr, 16'h4001);
    chk("R8 b2b strobe", mem_rd, 1);
  endtask

  task automatic t_priority;
    logic [15:0] p;
    @(negedge clk);
    op_code = OP_PTR_LOAD; op_imm = 16'h0102;
    sfr_we = 1'b1; sfr_addr = SFR_PTR_LO; sfr_wdata = 8'hFF;
    @(negedge clk);
    op_code = OP_NONE; sfr_we = 1'b0;
    read_ptr(p); chk("R11 load wins", p, 16'h0102);
    @(negedge clk);
    op_code = OP_PTR_INC;
    sfr_we = 1'b1; sfr_addr = SFR_PTR_HI; sfr_wdata = 8'hEE;
    @(negedge clk);
    op_code = OP_NONE; sfr_we = 1'b0;
    read_ptr(p); chk("R11 inc wins", p, 16'h0103);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_paged();
    t_pointer();
    t_select();
    t_isolation();
    t_wrap();
    t_interleave();
    t_priority();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule